// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This unit executes the second byte of a two-byte prefixed instruction class of an 8-bit processor core. It receives that opcode byte together with the 8-bit operand value already fetched by the surrounding pipeline and the current Z, N, H and C flags. It decodes the byte into one of three kinds of operation. The first is a shift or rotate family, which also contains a nibble swap. The second is a single-bit test. The third is a single-bit clear or set. The unit returns the result byte, the new flags, the index of the operand register, a write-enable for the result, and the duration of the instruction in clock ticks.

The operation is issued by pulsing `op_valid` with the opcode, operand and flags. All outputs are registered and appear one clock later, qualified by `res_valid`. The unit does not fetch operands and does not write them back. The caller uses `reg_sel` and `wr_en` to do both, and uses `ticks` to schedule the next instruction.

Top module: `pfx_unit`

## Requirements
- R1: After reset, `res_valid`, `wr_en`, `result`, `flags_out`, `reg_sel` and `ticks` are all zero.
- R2: An operation issued with `op_valid` high produces its outputs on the next clock edge, with `res_valid` high. `reg_sel` equals opcode bits 2:0, where 0..7 stand for B, C, D, E, H, L, memory-via-HL and A.
- R3: Opcode bits 7:6 select the operation class: 00 shift/rotate/swap, 01 bit test, 10 bit clear, 11 bit set. In class 00, bits 5:3 select kinds 0..7 = RLC, RRC, RL, RR, SLA, SRA, SWAP, SRL. RLC and RRC move the end bit that is shifted out into the opposite end, and C takes that bit.
- R4: RL and RR rotate through the incoming C. The incoming C enters the vacated end, and the outgoing end bit becomes the new C.
- R5: SLA shifts left and fills bit 0 with 0. SRL shifts right and fills bit 7 with 0. SRA shifts right and keeps bit 7. For all three, C takes the bit shifted out.
- R6: SWAP exchanges the high and low nibbles, sets Z from the result, and clears N, H and C.
- R7: All class-00 operations set Z when the result is zero and clear N and H. `flags_out` is packed as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C, and `flags_in` uses the same packing.
- R8: Bit test (class 01, bit number in bits 5:3) sets Z when the selected operand bit is 0, clears N, sets H, and keeps the incoming C. `wr_en` is low.
- R9: Bit clear and bit set (classes 10 and 11) change only the selected bit. `flags_out` equals `flags_in`.
- R10: `ticks` is 8 for a register operand. For the memory operand (`reg_sel` = 6), `ticks` is 12 for bit test and 16 for every other class.
- R11: A cycle with `op_valid` low drives `res_valid` and `wr_en` low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe for one operation |
| op_code | input | 8 | Second byte of the prefixed instruction |
| opnd | input | 8 | Operand value |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| res_valid | output | 1 | Outputs carry a completed operation |
| result | output | 8 | Result byte |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| reg_sel | output | 3 | Operand register index |
| wr_en | output | 1 | Result must be written back |
| ticks | output | 5 | Instruction duration in clock ticks |

## Verification
The bench builds the unit with its default parameters: an 8-bit datapath, a 5-bit tick field, and durations of 8, 12 and 16. With these three distinct durations, one bit-test and one clear/set case on the memory slot are enough to tell every duration class apart. With the 8-bit width, hand-picked operands such as 0x80, 0x81 and 0x01 push a bit out of each end. These operands show where each shift kind takes its fill bit from and that each one sets C.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int DW      = 8;
    localparam int SEL_W   = 3;
    localparam int BITN_W  = $clog2(DW);
    localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        K_RLC  = 3'd0,
        K_RRC  = 3'd1,
        K_RL   = 3'd2,
        K_RR   = 3'd3,
        K_SLA  = 3'd4,
        K_SRA  = 3'd5,
        K_SWAP = 3'd6,
        K_SRL  = 3'd7
    } kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        grp_e              grp;
        kind_e             kind;
        logic [BITN_W-1:0] bitn;
        logic [SEL_W-1:0]  sel;
        logic              is_mem;
    } dec_t;
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
    import pfx_pkg::*;
(
    input  logic [7:0] code,
    output dec_t       dec
);
    always_comb begin
        dec.grp    = grp_e'(code[7:6]);
        dec.kind   = kind_e'(code[5:3]);
        dec.bitn   = code[5:3];
        dec.sel    = code[2:0];
        dec.is_mem = (code[2:0] == SEL_MEM);
    end
endmodule

// File: rtl/pfx_rotshift.sv
module pfx_rotshift
    import pfx_pkg::*;
#(
    parameter int W = DW
) (
    input  kind_e        kind,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int HALF = W / 2;

    always_comb begin
        res  = a;
        cout = 1'b0;
        unique case (kind)
            K_RLC: begin
                res  = {a[W-2:0], a[W-1]};
                cout = a[W-1];
            end
            K_RRC: begin
                res  = {a[0], a[W-1:1]};
                cout = a[0];
            end
            K_RL: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            K_RR: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            K_SLA: begin
                res  = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            K_SRA: begin
                res  = {a[W-1], a[W-1:1]};
                cout = a[0];
            end
            K_SWAP: begin
                res  = {a[HALF-1:0], a[W-1:HALF]};
                cout = 1'b0;
            end
            K_SRL: begin
                res  = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            default: begin
                res  = a;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pfx_bitop.sv
module pfx_bitop
    import pfx_pkg::*;
#(
    parameter int W  = DW,
    parameter int BW = $clog2(W)
) (
    input  grp_e          grp,
    input  logic [BW-1:0] bitn,
    input  logic [W-1:0]  a,
    output logic [W-1:0]  res,
    output logic          bit_val
);
    logic [W-1:0] hot;

    for (genvar i = 0; i < W; i++) begin : g_hot
        assign hot[i] = (bitn == BW'(i));
    end

    always_comb begin
        bit_val = |(a & hot);
        unique case (grp)
            GRP_CLR: res = a & ~hot;
            GRP_SET: res = a | hot;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/pfx_unit.sv
module pfx_unit
    import pfx_pkg::*;
#(
    parameter int TICK_W         = 5,
    parameter int TICKS_REG      = 8,
    parameter int TICKS_MEM_TEST = 12,
    parameter int TICKS_MEM      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [DW-1:0]     opnd,
    input  logic [3:0]        flags_in,
    output logic              res_valid,
    output logic [DW-1:0]     result,
    output logic [3:0]        flags_out,
    output logic [SEL_W-1:0]  reg_sel,
    output logic              wr_en,
    output logic [TICK_W-1:0] ticks
);
    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [DW-1:0]     res;
        flags_t            flags;
        logic [SEL_W-1:0]  sel;
        logic [TICK_W-1:0] ticks;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;
    flags_t fin;
    logic [DW-1:0] sh_res, bo_res;
    logic          sh_c, bo_bit;

    assign fin = flags_t'(flags_in);

    pfx_decode u_dec (
        .code (op_code),
        .dec  (dec)
    );

    pfx_rotshift #(.W(DW)) u_sh (
        .kind (dec.kind),
        .a    (opnd),
        .cin  (fin.c),
        .res  (sh_res),
        .cout (sh_c)
    );

    pfx_bitop #(.W(DW)) u_bo (
        .grp     (dec.grp),
        .bitn    (dec.bitn),
        .a       (opnd),
        .res     (bo_res),
        .bit_val (bo_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid;
        st_d.wr    = 1'b0;
        if (op_valid) begin
            st_d.sel = dec.sel;
            if (!dec.is_mem)
                st_d.ticks = TICK_W'(TICKS_REG);
            else if (dec.grp == GRP_TEST)
                st_d.ticks = TICK_W'(TICKS_MEM_TEST);
            else
                st_d.ticks = TICK_W'(TICKS_MEM);
            unique case (dec.grp)
                GRP_SHIFT: begin
                    st_d.res     = sh_res;
                    st_d.wr      = 1'b1;
                    st_d.flags.z = (sh_res == '0);
                    st_d.flags.n = 1'b0;
                    st_d.flags.h = 1'b0;
                    st_d.flags.c = sh_c;
                end
                GRP_TEST: begin
                    st_d.res     = opnd;
                    st_d.wr      = 1'b0;
                    st_d.flags.z = ~bo_bit;
                    st_d.flags.n = 1'b0;
                    st_d.flags.h = 1'b1;
                    st_d.flags.c = fin.c;
                end
                default: begin
                    st_d.res   = bo_res;
                    st_d.wr    = 1'b1;
                    st_d.flags = fin;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign wr_en     = st_q.wr;
    assign result    = st_q.res;
    assign flags_out = st_q.flags;
    assign reg_sel   = st_q.sel;
    assign ticks     = st_q.ticks;
endmodule

// File: rtl/pfx_unit_chk.sv
module pfx_unit_chk #(
    parameter int TICK_W         = 5,
    parameter int TICKS_REG      = 8,
    parameter int TICKS_MEM_TEST = 12,
    parameter int TICKS_MEM      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [7:0]        op_code,
    input logic [7:0]        opnd,
    input logic [3:0]        flags_in,
    input logic              res_valid,
    input logic [7:0]        result,
    input logic [3:0]        flags_out,
    input logic [2:0]        reg_sel,
    input logic              wr_en,
    input logic [TICK_W-1:0] ticks
);
    AST_ISSUE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid && reg_sel == $past(op_code[2:0])); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && !wr_en); // R11
    AST_SHIFT_NH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[7:6] == 2'b00 |=> flags_out[2:1] == 2'b00 && wr_en && flags_out[3] == (result == 8'h00)); // R7
    AST_SWAP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[7:3] == 5'b00110 |=> !flags_out[0]); // R6
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[7:6] == 2'b01 |=> !wr_en && flags_out[1] && !flags_out[2] && flags_out[0] == $past(flags_in[0])); // R8
    AST_SETCLR_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[7] |=> flags_out == $past(flags_in) && wr_en); // R9
    AST_REG_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[2:0] != 3'd6 |=> ticks == TICK_W'(TICKS_REG)); // R10
    AST_MEM_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[2:0] == 3'd6 |=> ticks == (($past(op_code[7:6]) == 2'b01) ? TICK_W'(TICKS_MEM_TEST) : TICK_W'(TICKS_MEM))); // R10
endmodule

bind pfx_unit pfx_unit_chk #(
    .TICK_W         (TICK_W),
    .TICKS_REG      (TICKS_REG),
    .TICKS_MEM_TEST (TICKS_MEM_TEST),
    .TICKS_MEM      (TICKS_MEM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd      (opnd),
    .flags_in  (flags_in),
    .res_valid (res_valid),
    .result    (result),
    .flags_out (flags_out),
    .reg_sel   (reg_sel),
    .wr_en     (wr_en),
    .ticks     (ticks)
);

// File: tb/sim_pfx_unit.sv
`timescale 1ns/1ps
module sim_pfx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] opnd = 8'h00;
    logic [3:0] flags_in = 4'h0;
    logic       res_valid;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic [2:0] reg_sel;
    logic       wr_en;
    logic [4:0] ticks;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pfx_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opnd      (opnd),
        .flags_in  (flags_in),
        .res_valid (res_valid),
        .result    (result),
        .flags_out (flags_out),
        .reg_sel   (reg_sel),
        .wr_en     (wr_en),
        .ticks     (ticks)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    // Issue one operation, then sample the registered outputs a full cycle later.
    task automatic issue(input logic [7:0] c, input logic [7:0] a, input logic [3:0] f);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = c;
        opnd     = a;
        flags_in = f;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_all(input string req, input logic [7:0] r, input logic [3:0] f,
                              input logic w, input logic [4:0] t, input logic [2:0] s);
        chk({req, " valid"}, 32'(res_valid), 32'd1);
        chk({req, " result"}, 32'(result), 32'(r));
        chk({req, " flags"}, 32'(flags_out), 32'(f));
        chk({req, " wr_en"}, 32'(wr_en), 32'(w));
        chk({req, " ticks"}, 32'(ticks), 32'(t));
        chk({req, " reg_sel"}, 32'(reg_sel), 32'(s));
    endtask

    task automatic t_reset;
        chk("R1 valid", 32'(res_valid), 0);
        chk("R1 wr_en", 32'(wr_en), 0);
        chk("R1 result", 32'(result), 0);
        chk("R1 flags", 32'(flags_out), 0);
        chk("R1 reg_sel", 32'(reg_sel), 0);
        chk("R1 ticks", 32'(ticks), 0);
    endtask

    task automatic t_rot_own;
        issue(8'h00, 8'h85, 4'h0); expect_all("R3 RLC B", 8'h0B, 4'b0001, 1, 8, 0);
        issue(8'h09, 8'h01, 4'h0); expect_all("R3 RRC C", 8'h80, 4'b0001, 1, 8, 1);
        issue(8'h01, 8'h40, 4'h1); expect_all("R2 RLC C", 8'h80, 4'b0000, 1, 8, 1);
    endtask

    task automatic t_rot_carry;
        issue(8'h12, 8'h80, 4'h0); expect_all("R4 RL D zero", 8'h00, 4'b1001, 1, 8, 2);
        issue(8'h12, 8'h00, 4'h1); expect_all("R4 RL D cin", 8'h01, 4'b0000, 1, 8, 2);
        issue(8'h1B, 8'h01, 4'h1); expect_all("R4 RR E", 8'h80, 4'b0001, 1, 8, 3);
    endtask

    task automatic t_shifts;
        issue(8'h24, 8'hFF, 4'h1); expect_all("R5 SLA H", 8'hFE, 4'b0001, 1, 8, 4);
        issue(8'h2D, 8'h81, 4'h0); expect_all("R5 SRA L", 8'hC0, 4'b0001, 1, 8, 5);
        issue(8'h3F, 8'h81, 4'h0); expect_all("R5 SRL A", 8'h40, 4'b0001, 1, 8, 7);
        issue(8'h27, 8'h80, 4'b0110); expect_all("R7 SLA A zero", 8'h00, 4'b1001, 1, 8, 7);
    endtask

    task automatic t_swap;
        issue(8'h36, 8'hF0, 4'hF); expect_all("R6 SWAP mem", 8'h0F, 4'b0000, 1, 16, 6);
        issue(8'h37, 8'h00, 4'h1); expect_all("R6 SWAP A zero", 8'h00, 4'b1000, 1, 8, 7);
    endtask

    task automatic t_bit_test;
        issue(8'h7F, 8'h7F, 4'b0001); expect_all("R8 BIT7 A", 8'h7F, 4'b1011, 0, 8, 7);
        issue(8'h46, 8'h01, 4'b1100); expect_all("R10 BIT0 mem", 8'h01, 4'b0010, 0, 12, 6);
    endtask

    task automatic t_clr_set;
        issue(8'h98, 8'hFF, 4'b1010); expect_all("R9 RES3 B", 8'hF7, 4'b1010, 1, 8, 0);
        issue(8'h81, 8'h01, 4'b0000); expect_all("R9 RES0 C", 8'h00, 4'b0000, 1, 8, 1);
        issue(8'hFE, 8'h00, 4'b0101); expect_all("R10 SET7 mem", 8'h80, 4'b0101, 1, 16, 6);
    endtask

    task automatic t_idle;
        issue(8'hC0, 8'h00, 4'h0);
        @(negedge clk);
        chk("R11 valid", 32'(res_valid), 0);
        chk("R11 wr_en", 32'(wr_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_rot_own();
        t_rot_carry();
        t_shifts();
        t_swap();
        t_bit_test();
        t_clr_set();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule